// File: doc/BRIEF.md
# Dual-Clock Cell Receive Buffer

This block moves fixed-size 53-byte ATM cells from a receive-side line clock into a system clock. The two clocks are unrelated. The line side pushes one byte per clock, flagged valid. The first byte of every cell carries a start-of-cell flag. The line side cannot be stalled. The buffer therefore decides at the start of each cell whether the cell fits. If it does not fit, the whole cell is thrown away.

Storage is counted in whole cells, 32 of them by default. A cell becomes visible to the reader only after its last byte has been stored. The reader therefore never sees a partial cell. A cell-available flag tells the reader that a complete cell is waiting. The reader then pops bytes one per clock, and a start-of-cell marker accompanies the first byte of each cell.

Cell indices cross between the clock domains as Gray codes through two-stage synchronisers. Two saturating counters in the line domain record the cells dropped for lack of room and the partial cells abandoned because a new start-of-cell arrived early.

Top module: `cell_rx_fifo`

## Requirements
- R1: After reset, rdAvail is 0, ovfCount is 0 and frameErrCount is 0.
- R2: A cell is a byte with wrValid=1 and wrSoc=1, followed by 52 bytes with wrValid=1 and wrSoc=0. The reader receives the same 53 bytes in the same order.
- R3: A cell stays invisible (rdAvail=0) until its 53rd byte has been written. rdAvail rises within a few read clocks after that byte.
- R4: Up to DEPTH_CELLS (32) complete cells are held. They are read out in the order in which they were written, and the indices wrap without loss.
- R5: If a start-of-cell byte arrives while DEPTH_CELLS cells are stored, that whole cell is discarded and ovfCount increments by one. The stored cells are not affected.
- R6: If a start-of-cell byte arrives before the open cell has all 53 bytes, the partial cell is discarded and frameErrCount increments by one. Storing then restarts with the new cell.
- R7: Bytes with wrSoc=0 that arrive while no cell is open are ignored, as are all cycles with wrValid=0. Neither affects stored data, rdAvail or the counters.
- R8: rdSoc is 1 exactly when rdAvail=1 and rdData holds byte 0 of a cell. When rdEn=1 and rdAvail=1, one byte is consumed on the read clock edge. When rdEn=1 and rdAvail=0, rdEn is ignored.
- R9: The synchronised write index seen by the read domain changes by at most one bit per read clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Line-side receive clock |
| wrRstN | input | 1 | Active-low reset, line domain |
| wrValid | input | 1 | A byte is present on wrData |
| wrSoc | input | 1 | The byte is the first byte of a cell |
| wrData | input | 8 | Received byte |
| ovfCount | output | CNT_W | Cells dropped because the buffer was full (saturating) |
| frameErrCount | output | CNT_W | Partial cells abandoned because of an early start (saturating) |
| rdClk | input | 1 | System-side clock |
| rdRstN | input | 1 | Active-low reset, system domain |
| rdEn | input | 1 | Consume the presented byte |
| rdAvail | output | 1 | A complete cell is stored |
| rdSoc | output | 1 | rdData is the first byte of a cell |
| rdData | output | 8 | Presented byte |

## Verification
The assertions check on every cycle that each side's view of the stored count never exceeds the depth. They also check that the write index advances only on a cell's final byte and that a dropped cell leaves the index unchanged. Further per-cycle checks cover the counters, which step by one at a time, the read position, which holds without a pop, and the synchronised Gray index, which changes by no more than one bit per read clock. The byte content of each cell, the order of cells, and the invisibility of a partial cell can only be shown by the bench's scenarios. The same holds for discarding on overflow and early starts, and for ignoring stray bytes and pops on an empty buffer. The bench runs these scenarios and follows them with a long sweep that wraps the indices.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;
  // per-byte strobes from control to datapath (line domain)
  typedef struct packed {
    logic memWe;
    logic ovfInc;
    logic ferInc;
  } wrStrobe_t;
endpackage

// File: rtl/cell_rx_dpath.sv
module cell_rx_dpath
  import cell_rx_pkg::*;
#(
  parameter int CELL_BYTES  = 53,
  parameter int DEPTH_CELLS = 32,
  parameter int CNT_W       = 16,
  localparam int ENTRIES    = CELL_BYTES * DEPTH_CELLS,
  localparam int AW         = $clog2(ENTRIES)
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  wrStrobe_t        wrStb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [7:0]       wrData,
  output logic [CNT_W-1:0] ovfCount,
  output logic [CNT_W-1:0] frameErrCount,
  input  logic [AW-1:0]    rdAddr,
  output logic [7:0]       rdData
);
  logic [7:0] mem [ENTRIES];

  always_ff @(posedge wrClk) begin
    if (wrStb.memWe) mem[wrAddr] <= wrData;
  end

  assign rdData = mem[rdAddr];

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      ovfCount      <= '0;
      frameErrCount <= '0;
    end else begin
      if (wrStb.ovfInc && ovfCount != '1)      ovfCount      <= ovfCount + 1'b1;
      if (wrStb.ferInc && frameErrCount != '1) frameErrCount <= frameErrCount + 1'b1;
    end
  end

  p_ovf_step_r5: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !$stable(ovfCount) |-> (ovfCount == $past(ovfCount) + 1'b1));
  p_fer_step_r6: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !$stable(frameErrCount) |-> (frameErrCount == $past(frameErrCount) + 1'b1));
endmodule

// File: rtl/cell_rx_ctrl.sv
module cell_rx_ctrl
  import cell_rx_pkg::*;
#(
  parameter int CELL_BYTES  = 53,
  parameter int DEPTH_CELLS = 32,
  localparam int CW         = $clog2(DEPTH_CELLS),
  localparam int PW         = CW + 1,
  localparam int BW         = $clog2(CELL_BYTES),
  localparam int AW         = $clog2(CELL_BYTES * DEPTH_CELLS),
  localparam int LAST       = CELL_BYTES - 1
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrValid,
  input  logic          wrSoc,
  output wrStrobe_t     wrStb,
  output logic [AW-1:0] wrAddr,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdEn,
  output logic          rdAvail,
  output logic          rdSoc,
  output logic [AW-1:0] rdAddr
);
  // ---------------- line (write) domain ----------------
  logic [PW-1:0] wrPtr, wrGray, rdGraySyncA, rdGraySyncB, rdPtrInW;
  logic [BW-1:0] wrIdx, wrIdxEff;
  logic          inCell, wrFull, wrLastByte;
  logic [PW-1:0] wrPtrInc;

  always_comb begin
    for (int i = 0; i < PW; i++) rdPtrInW[i] = ^(rdGraySyncB >> i);
  end

  assign wrFull     = (wrPtr - rdPtrInW) == PW'(DEPTH_CELLS);
  assign wrLastByte = wrIdx == BW'(LAST);
  assign wrIdxEff   = wrSoc ? '0 : wrIdx;
  assign wrPtrInc   = wrPtr + 1'b1;
  assign wrAddr     = AW'(wrPtr[CW-1:0] * CELL_BYTES) + AW'(wrIdxEff);

  always_comb begin
    wrStb        = '0;
    wrStb.memWe  = wrValid && (wrSoc ? !wrFull : inCell);
    wrStb.ovfInc = wrValid && wrSoc && wrFull;
    wrStb.ferInc = wrValid && wrSoc && inCell;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtr       <= '0;
      wrGray      <= '0;
      wrIdx       <= '0;
      inCell      <= 1'b0;
      rdGraySyncA <= '0;
      rdGraySyncB <= '0;
    end else begin
      rdGraySyncA <= rdGray;
      rdGraySyncB <= rdGraySyncA;
      if (wrValid) begin
        if (wrSoc) begin
          inCell <= !wrFull;
          wrIdx  <= BW'(1);
        end else if (inCell) begin
          if (wrLastByte) begin
            inCell <= 1'b0;
            wrIdx  <= '0;
            wrPtr  <= wrPtrInc;
            wrGray <= wrPtrInc ^ (wrPtrInc >> 1);
          end else begin
            wrIdx <= wrIdx + BW'(1);
          end
        end
      end
    end
  end

  // ---------------- system (read) domain ----------------
  logic [PW-1:0] rdPtr, rdGray, wrGraySyncA, wrGraySyncB, wrPtrInR, rdPtrInc;
  logic [BW-1:0] rdIdx;

  always_comb begin
    for (int i = 0; i < PW; i++) wrPtrInR[i] = ^(wrGraySyncB >> i);
  end

  assign rdAvail  = rdPtr != wrPtrInR;
  assign rdSoc    = rdAvail && (rdIdx == '0);
  assign rdPtrInc = rdPtr + 1'b1;
  assign rdAddr   = AW'(rdPtr[CW-1:0] * CELL_BYTES) + AW'(rdIdx);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPtr       <= '0;
      rdGray      <= '0;
      rdIdx       <= '0;
      wrGraySyncA <= '0;
      wrGraySyncB <= '0;
    end else begin
      wrGraySyncA <= wrGray;
      wrGraySyncB <= wrGraySyncA;
      if (rdEn && rdAvail) begin
        if (rdIdx == BW'(LAST)) begin
          rdIdx  <= '0;
          rdPtr  <= rdPtrInc;
          rdGray <= rdPtrInc ^ (rdPtrInc >> 1);
        end else begin
          rdIdx <= rdIdx + BW'(1);
        end
      end
    end
  end

  // ---------------- assertions ----------------
  p_wr_room_r4: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrPtr - rdPtrInW) <= PW'(DEPTH_CELLS));
  p_commit_last_r3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !$stable(wrPtr) |-> ($past(wrIdx) == BW'(LAST)));
  p_drop_keeps_ptr_r5: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrStb.ovfInc |=> $stable(wrPtr));
  p_rd_room_r4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (wrPtrInR - rdPtr) <= PW'(DEPTH_CELLS));
  p_rd_hold_r8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdEn |=> ($stable(rdPtr) && $stable(rdIdx)));
  // holds because the write index moves at most once per CELL_BYTES line clocks
  p_gray_step_r9: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(wrGraySyncB ^ $past(wrGraySyncB)) <= 1);
endmodule

// File: rtl/cell_rx_fifo.sv
module cell_rx_fifo
  import cell_rx_pkg::*;
#(
  parameter int CELL_BYTES  = 53,
  parameter int DEPTH_CELLS = 32,
  parameter int CNT_W       = 16
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrValid,
  input  logic             wrSoc,
  input  logic [7:0]       wrData,
  output logic [CNT_W-1:0] ovfCount,
  output logic [CNT_W-1:0] frameErrCount,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic             rdEn,
  output logic             rdAvail,
  output logic             rdSoc,
  output logic [7:0]       rdData
);
  localparam int AW = $clog2(CELL_BYTES * DEPTH_CELLS);

  wrStrobe_t     wrStb;
  logic [AW-1:0] wrAddr, rdAddr;

  cell_rx_ctrl #(.CELL_BYTES(CELL_BYTES), .DEPTH_CELLS(DEPTH_CELLS)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrSoc(wrSoc),
    .wrStb(wrStb), .wrAddr(wrAddr),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn),
    .rdAvail(rdAvail), .rdSoc(rdSoc), .rdAddr(rdAddr)
  );

  cell_rx_dpath #(.CELL_BYTES(CELL_BYTES), .DEPTH_CELLS(DEPTH_CELLS), .CNT_W(CNT_W)) u_dpath (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .ovfCount(ovfCount), .frameErrCount(frameErrCount),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/cell_rx_fifo_tb.sv
`timescale 1ns/100ps
module cell_rx_fifo_tb;
  localparam int CB = 53;
  localparam int DC = 32;
  localparam int CW = 16;

  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0;
  logic wrValid = 0, wrSoc = 0, rdEn = 0;
  logic [7:0] wrData = '0;
  logic [CW-1:0] ovfCount, frameErrCount;
  logic rdAvail, rdSoc;
  logic [7:0] rdData;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 rdClk = ~rdClk;
  always #25.5 wrClk = ~wrClk;

  cell_rx_fifo #(.CELL_BYTES(CB), .DEPTH_CELLS(DC), .CNT_W(CW)) u_dut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrSoc(wrSoc), .wrData(wrData),
    .ovfCount(ovfCount), .frameErrCount(frameErrCount),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn),
    .rdAvail(rdAvail), .rdSoc(rdSoc), .rdData(rdData)
  );

  function automatic logic [7:0] pat(input int seq, input int idx);
    return 8'((seq * 7) + (idx * 13) + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bytes first..first+cnt-1 of cell seq; byte 0 carries the start flag
  task automatic sendPart(input int seq, input int first, input int cnt);
    for (int i = first; i < first + cnt; i++) begin
      @(negedge wrClk);
      wrValid = 1; wrSoc = (i == 0); wrData = pat(seq, i);
    end
    @(negedge wrClk);
    wrValid = 0; wrSoc = 0;
  endtask

  task automatic waitWr(input int n);
    for (int i = 0; i < n; i++) @(negedge wrClk);
  endtask

  task automatic readCell(input int seq, input string req);
    int w = 0;
    @(negedge rdClk);
    while (!rdAvail && w < 400) begin @(negedge rdClk); w++; end
    chk(rdAvail, req, int'(rdAvail), 1);
    for (int i = 0; i < CB; i++) begin
      if (i > 0) @(negedge rdClk);
      chk(rdData == pat(seq, i), req, int'(rdData), int'(pat(seq, i)));
      chk(rdSoc == (i == 0), "R8 soc marker", int'(rdSoc), int'(i == 0));
      rdEn = 1;
    end
    @(negedge rdClk);
    rdEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge rdClk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitWr(3);
    wrRstN = 1; rdRstN = 1;
    waitWr(2);
    // R1 reset state
    chk(rdAvail == 0, "R1 avail", int'(rdAvail), 0);
    chk(ovfCount == 0, "R1 ovf", int'(ovfCount), 0);
    chk(frameErrCount == 0, "R1 fer", int'(frameErrCount), 0);

    // R7 stray bytes and idle start flags ignored
    sendPart(900, 1, 10);
    for (int i = 0; i < 3; i++) begin @(negedge wrClk); wrValid = 0; wrSoc = 1; end
    wrSoc = 0;
    waitWr(6);
    chk(rdAvail == 0, "R7 stray avail", int'(rdAvail), 0);
    chk(frameErrCount == 0 && ovfCount == 0, "R7 counters", int'(frameErrCount + ovfCount), 0);

    // R3 partial cell invisible
    sendPart(0, 0, CB - 1);
    waitWr(8);
    chk(rdAvail == 0, "R3 partial hidden", int'(rdAvail), 0);
    sendPart(0, CB - 1, 1);
    waitWr(3);
    chk(rdAvail == 1, "R3 visible after last", int'(rdAvail), 1);
    readCell(0, "R2 content");
    waitWr(2);
    chk(rdAvail == 0, "R8 empty after read", int'(rdAvail), 0);

    // R8 pops on an empty buffer ignored
    @(negedge rdClk); rdEn = 1;
    repeat (5) @(negedge rdClk);
    rdEn = 0;
    sendPart(1, 0, CB);
    readCell(1, "R8 empty pop ignored");

    // R6 early start after 20 bytes
    sendPart(2, 0, 20);
    sendPart(3, 0, CB);
    waitWr(2);
    chk(frameErrCount == 1, "R6 fer count", int'(frameErrCount), 1);
    readCell(3, "R6 new cell kept");
    waitWr(3);
    chk(rdAvail == 0, "R6 partial gone", int'(rdAvail), 0);

    // R6 early start at the final byte position
    sendPart(4, 0, CB - 1);
    sendPart(5, 0, CB);
    waitWr(2);
    chk(frameErrCount == 2, "R6 fer boundary", int'(frameErrCount), 2);
    readCell(5, "R6 boundary cell");
    waitWr(5);

    // R5 / R4 fill to depth, two cells dropped
    for (int k = 0; k < DC; k++) sendPart(10 + k, 0, CB);
    sendPart(100, 0, CB);
    sendPart(101, 0, CB);
    waitWr(2);
    chk(ovfCount == 2, "R5 ovf count", int'(ovfCount), 2);
    for (int k = 0; k < DC; k++) readCell(10 + k, "R4 order at depth");
    waitWr(3);
    chk(rdAvail == 0, "R5 dropped cells absent", int'(rdAvail), 0);
    waitWr(5);

    // R4 sweep: indices wrap many times, varied occupancy
    for (int k = 0; k < 70; k++) begin
      sendPart(200 + k, 0, CB);
      if (k % 3 == 2) begin
        readCell(200 + k - 2, "R4 sweep");
        readCell(200 + k - 1, "R4 sweep");
        readCell(200 + k, "R4 sweep");
      end
    end
    readCell(269, "R4 sweep tail");
    waitWr(3);
    chk(rdAvail == 0, "R4 drained", int'(rdAvail), 0);
    chk(ovfCount == 2 && frameErrCount == 2, "R5 counters steady",
        int'(ovfCount + frameErrCount), 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule